// File: doc/BRIEF.md
# Program Busy Status Reporter

This block sits in the read path of a byte-wide nonvolatile memory model. While no program cycle is in progress, every read access returns the array byte unchanged. While a program cycle runs, reads are overridden to report progress in two ways at once. Bit 7 carries the inverse of bit 7 of the most recently loaded byte (data polling). Bit 6 flips on every new read access (toggle bit). Software may watch either indication to find out when the cycle ends.

The read-access strobe is the decoded "read in progress" condition, asserted whichever of the chip-enable or output-enable lines ends up opening the access. The block detects the rising edge of that strobe with the system clock, so a strobe held high across several clocks counts as one access. The returned byte is registered: it is updated on every clock where the strobe is high and held while the strobe is low. The loaded-data input is whatever the write path last captured. For a rejected, unprotected write, that is the rejected byte.

Top module: `prog_status_rdpath`

## Requirements
- R1: After reset, rd_data is 0x00 and the toggle state is 0, so the first read access while busy returns bit 6 = 1.
- R2: With busy low, a clock edge where rd_strobe is high loads rd_data with arr_data, visible from the next cycle.
- R3: With busy high, a clock edge where rd_strobe is high loads rd_data bit 7 with the inverse of ld_data bit 7.
- R4: With busy high, a clock edge where rd_strobe is high loads rd_data bits 5..0 with ld_data bits 5..0.
- R5: With busy high, each rising edge of rd_strobe (high now, low on the previous clock) inverts the toggle state, and that new value appears on rd_data bit 6 for that access.
- R6: While rd_strobe stays high over several clocks, the toggle state does not change and bit 6 stays constant.
- R7: When busy is low, the toggle state is frozen, and all eight bits of a read equal arr_data. After busy returns high, the toggle continues from the frozen value.
- R8: A clock edge with rd_strobe low leaves rd_data unchanged, even when busy, ld_data or arr_data change.
- R9: If busy rises while rd_strobe is already held high, the status word replaces array data on the next clock, with bit 6 showing the unchanged toggle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | High while a program cycle (real or dummy) is running |
| rd_strobe | input | 1 | Decoded read access in progress |
| ld_data | input | DATA_W | Last byte captured by the write path |
| arr_data | input | DATA_W | Byte read from the array |
| rd_data | output | DATA_W | Registered read data returned to the bus |

## Verification
Idle reads use several array bytes, including 0x00, 0xFF and alternating patterns, so that a wrong source for any single bit shows up. Busy reads use loaded bytes with bit 7 both set and clear and differing low bits. This separates the inverted poll bit from a pass-through bit and from the toggle position. Single-clock strobe pulses check that bit 6 alternates, while strobes held over several clocks and a busy rise during a held strobe check that a level is never taken for an edge. Busy-to-idle-to-busy sequences with strobe-low gaps in between check both the freeze of the toggle and that rd_data holds its value between accesses.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    // state of the strobe edge detector
    typedef struct packed {
        logic lvl;
    } rise_st_t;

    // state of the toggle tracker
    typedef struct packed {
        logic tog;
    } tog_st_t;
endpackage

// File: rtl/bsr_rise.sv
module bsr_rise
    import bsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    rise_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = strobe;
        rise     = strobe && !st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bsr_toggle.sv
module bsr_toggle
    import bsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rise,
    output logic tog_next,
    output logic tog_cur
);
    tog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy && rise) st_d.tog = !st_q.tog;
        tog_next = st_d.tog;
        tog_cur  = st_q.tog;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rise) |=> (tog_cur != $past(tog_cur)));

    // R6
    toggle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise) |=> $stable(tog_cur));
endmodule

// File: rtl/bsr_merge.sv
module bsr_merge #(
    parameter int DATA_W = 8
) (
    input  logic              busy,
    input  logic              tog_bit,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] word
);
    localparam int POLL_IDX = DATA_W - 1;
    localparam int TOG_IDX  = DATA_W - 2;

    logic [DATA_W-1:0] status;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POLL_IDX) begin : g_poll
            assign status[i] = !ld_data[i];
        end else if (i == TOG_IDX) begin : g_tog
            assign status[i] = tog_bit;
        end else begin : g_pass
            assign status[i] = ld_data[i];
        end
    end

    assign word = busy ? status : arr_data;
endmodule

// File: rtl/prog_status_rdpath.sv
module prog_status_rdpath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int POLL_IDX = DATA_W - 1;
    localparam int LOW_W    = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } out_st_t;

    out_st_t           st_d, st_q;
    logic              rise;
    logic              tog_next;
    logic              tog_cur;
    logic [DATA_W-1:0] word;

    bsr_rise u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_strobe),
        .rise   (rise)
    );

    bsr_toggle u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .rise     (rise),
        .tog_next (tog_next),
        .tog_cur  (tog_cur)
    );

    bsr_merge #(.DATA_W(DATA_W)) u_merge (
        .busy     (busy),
        .tog_bit  (tog_next),
        .ld_data  (ld_data),
        .arr_data (arr_data),
        .word     (word)
    );

    always_comb begin
        st_d = st_q;
        if (rd_strobe) st_d.data = word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;

    // R2
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !busy) |=> (rd_data == $past(arr_data)));

    // R3
    poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy) |=> (rd_data[POLL_IDX] == !$past(ld_data[POLL_IDX])));

    // R4
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy) |=> (rd_data[LOW_W-1:0] == $past(ld_data[LOW_W-1:0])));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe) |=> $stable(rd_data));

    // R9
    late_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy && !rise) |=> (rd_data[DATA_W-2] == $past(tog_cur)));
endmodule

// File: tb/sim_prog_status_rdpath.sv
module sim_prog_status_rdpath;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] ld_data = 8'h00;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
        int         due;
    } item_t;
    item_t sb[$];

    bit         m_tog = 1'b0;
    bit         m_prev = 1'b0;
    logic [7:0] m_out = 8'h00;

    always #5 clk = ~clk;

    prog_status_rdpath u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .rd_strobe (rd_strobe),
        .ld_data   (ld_data),
        .arr_data  (arr_data),
        .rd_data   (rd_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares after the clock edge that loads the result
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s: rd_data=%02h expected=%02h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    // driver: one clock of stimulus, called right after a falling edge
    task automatic step(input bit stb, input bit bsy, input logic [7:0] ld,
                        input logic [7:0] arr, input string tag, input bit chk);
        item_t it;
        bit rise;
        busy = bsy; rd_strobe = stb; ld_data = ld; arr_data = arr;
        rise = stb && !m_prev;
        if (stb) begin
            if (bsy && rise) m_tog = !m_tog;
            m_out = bsy ? {~ld[7], m_tog, ld[5:0]} : arr;
        end
        m_prev = stb;
        if (chk) begin
            it.exp = m_out; it.tag = tag; it.due = cyc + 1;
            sb.push_back(it);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rd_data !== 8'h00) begin
            errors++;
            $display("FAIL R1: rd_data=%02h expected=00", rd_data);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 idle pass-through with several patterns, gaps check R8
        step(1, 0, 8'h12, 8'hA5, "R2", 1);
        step(0, 0, 8'h12, 8'h3C, "R8", 1);
        step(1, 0, 8'h00, 8'hFF, "R2", 1);
        step(0, 0, 8'h00, 8'h00, "R8", 1);
        step(1, 0, 8'hFF, 8'h00, "R2", 1);
        step(0, 0, 8'hFF, 8'h5A, "R8", 1);

        // R1/R3/R4/R5 busy pulses: bit6 goes 1,0,1
        step(1, 1, 8'h80, 8'hFF, "R1 R3 R5 first busy read", 1);
        step(0, 1, 8'h80, 8'hFF, "R8", 1);
        step(1, 1, 8'h3F, 8'h00, "R3 R4 R5", 1);
        step(0, 1, 8'h15, 8'h00, "R8 busy inputs change", 1);
        step(1, 1, 8'h55, 8'hAA, "R4 R5", 1);
        step(0, 1, 8'h55, 8'hAA, "R8", 1);

        // R6 held strobe while busy
        step(1, 1, 8'hC3, 8'h00, "R6 rise", 1);
        step(1, 1, 8'hC3, 8'h00, "R6 held", 1);
        step(1, 1, 8'h2A, 8'h00, "R6 held", 1);
        step(1, 1, 8'hC3, 8'h00, "R6 held", 1);
        step(0, 1, 8'hC3, 8'h00, "R8", 1);

        // R7 busy drops: true data, toggle frozen across idle reads
        step(1, 0, 8'hC3, 8'h96, "R7 idle all bits", 1);
        step(0, 0, 8'hC3, 8'h96, "R8", 1);
        step(1, 0, 8'hC3, 8'h40, "R7 idle all bits", 1);
        step(0, 0, 8'hC3, 8'h40, "R8", 1);
        step(1, 1, 8'h01, 8'h40, "R7 toggle resumes", 1);
        step(0, 1, 8'h01, 8'h40, "R8", 1);

        // R9 busy rises during a held strobe
        step(1, 0, 8'h7E, 8'h33, "R9 idle part", 1);
        step(1, 1, 8'h7E, 8'h33, "R9 busy mid-access", 1);
        step(1, 1, 8'h7E, 8'h33, "R9 still held", 1);
        step(0, 1, 8'h7E, 8'h33, "R8", 1);
        step(1, 1, 8'h7E, 8'h33, "R5 next access flips", 1);
        step(0, 0, 8'h7E, 8'h33, "R8", 1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule